// File: doc/BRIEF.md
# I2C Stuck-Bus Timeout Monitor

This block listens passively to the clock and data lines of an I2C bus and reports when the bus looks hung. It resynchronises both lines into its own clock domain and finds Start and Stop conditions itself. From these it keeps a bus-busy state that is set by a Start and cleared by a Stop. While the bus is busy and the block is enabled, two independent counters run against one programmable limit, measured in clock cycles.

The first counter measures the gap since the last bus event. A Start, a Stop and any edge of SCL all count as events. The second counter measures how long SCL has been held low without a break. Either counter reaching the limit raises a sticky flag together with a one-cycle pulse. Software or surrounding logic clears each flag with a write-one-to-clear pulse. The block takes no recovery action of its own. It only reports.

Top module: `i2c_stuck_mon`

## Requirements
- R1: A Start condition (SDA falling while SCL stays high) drives `bus_busy` to 1. With inputs changed just after a clock edge, `bus_busy` reads 0 after two further rising edges and 1 after three.
- R2: A Stop condition (SDA rising while SCL stays high) returns `bus_busy` to 0 on the third rising edge after the pin change.
- R3: While busy, with limit L nonzero and no bus event after the Start, `evt_to_flag` is 0 after L+3 rising edges and 1 after L+4 rising edges, counted from the pin change of the last event.
- R4: Each rising or falling edge of SCL restarts the event-gap count. SCL toggling with phases shorter than L cycles never raises `evt_to_flag`.
- R5: While busy, SCL held low without a break raises `scl_to_flag` on the (L+4)th rising edge after SCL falls. SCL held high never raises `scl_to_flag`.
- R6: Each flag stays at 1 until its own clear input is 1 for a cycle. The flag then reads 0 on the next edge, unless its timeout condition still holds.
- R7: `evt_to_pulse` and `scl_to_pulse` are each 1 for exactly the one cycle in which their flag goes from 0 to 1, and 0 otherwise.
- R8: A limit of 0 disables both comparisons, so no flag is raised however long the bus stays stuck.
- R9: With `enable` at 0, the busy state and both counters are held at zero, a Start is ignored, and no flag is raised.
- R10: While the bus is idle (after a Stop, or before any Start), neither timeout is raised, even with SCL held low.
- R11: When a clear and a new timeout fall in the same cycle, the set wins: the flag reads 1 and the pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Enables busy tracking and both timeouts |
| timeout_lim | input | LIM_W | Shared timeout limit in clock cycles; 0 disables |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| clr_evt_to | input | 1 | Write-one-to-clear for the event timeout flag |
| clr_scl_to | input | 1 | Write-one-to-clear for the SCL-low timeout flag |
| bus_busy | output | 1 | 1 between a Start and the following Stop |
| evt_to_flag | output | 1 | Sticky event-gap timeout flag |
| evt_to_pulse | output | 1 | One-cycle pulse when the event timeout flag sets |
| scl_to_flag | output | 1 | Sticky SCL-low timeout flag |
| scl_to_pulse | output | 1 | One-cycle pulse when the SCL-low timeout flag sets |

## Verification
Two things can fall in the same cycle: a flag's clear input and a fresh timeout on that same flag. The bench counts edges from the Start and raises `clr_evt_to` exactly in the cycle whose edge would first set the event flag. It expects the flag and its pulse to be 1 after that edge, so the set wins. It then holds the clear while the stuck condition lasts and expects the flag to stay at 1. A second overlap comes from SCL stuck low. Both counters restart on the same falling edge, so both flags must rise on the same edge. The bench checks this.

// File: rtl/i2c_stk_pkg.sv
package i2c_stk_pkg;
  // Decoded bus activity for one clock cycle, taken from the synchronised lines.
  typedef struct packed {
    logic start;     // SDA fell while SCL stayed high
    logic stop;      // SDA rose while SCL stayed high
    logic scl_rise;  // SCL went low to high
    logic scl_fall;  // SCL went high to low
    logic scl_lvl;   // current synchronised SCL level
  } bus_evt_t;
endpackage

// File: rtl/i2c_stk_sync.sv
module i2c_stk_sync
  import i2c_stk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_in,
  input  logic     sda_in,
  output bus_evt_t evt
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;
  logic              scl_now, sda_now;

  // Synchroniser chain. Idle bus level is high.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= (g == 0) ? scl_in : scl_ff[(g == 0) ? 0 : g - 1];
          sda_ff[g] <= (g == 0) ? sda_in : sda_ff[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign scl_now = scl_ff[LAST];
  assign sda_now = sda_ff[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_now;
    end
  end

  always_comb begin
    evt.scl_lvl  = scl_now;
    evt.scl_rise = scl_now & ~scl_prev;
    evt.scl_fall = ~scl_now & scl_prev;
    evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
    evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
  end
endmodule

// File: rtl/i2c_stk_busy.sv
module i2c_stk_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic stop,
  output logic busy
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (!en)        busy_d = 1'b0;
    else if (start) busy_d = 1'b1;
    else if (stop)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/i2c_stk_timer.sv
module i2c_stk_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             restart,
  input  logic [LIM_W-1:0] limit,
  input  logic             flag_clr,
  output logic             flag,
  output logic             pulse
);
  localparam logic [LIM_W-1:0] CNT_MAX = '1;

  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             hit;
  logic             flag_q, flag_d;
  logic             pulse_q, pulse_d;

  // The counter saturates, so a lowered limit still compares correctly.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!armed || restart) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != CNT_MAX) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_comb begin
    hit     = armed & ~restart & (limit != '0) & (cnt_q >= limit);
    flag_d  = hit | (flag_q & ~flag_clr);
    pulse_d = hit & ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign flag  = flag_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/i2c_stuck_mon.sv
module i2c_stuck_mon
  import i2c_stk_pkg::*;
#(
  parameter int LIM_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LIM_W-1:0] timeout_lim,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             clr_evt_to,
  input  logic             clr_scl_to,
  output logic             bus_busy,
  output logic             evt_to_flag,
  output logic             evt_to_pulse,
  output logic             scl_to_flag,
  output logic             scl_to_pulse
);
  logic     rst_meta, rst_int_n;
  bus_evt_t evt;
  logic     busy;
  logic     armed;
  logic     evt_restart, scl_restart;

  // Reset: asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  i2c_stk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_in(scl_in), .sda_in(sda_in), .evt(evt)
  );

  i2c_stk_busy u_busy (
    .clk(clk), .rst_n(rst_int_n), .en(enable),
    .start(evt.start), .stop(evt.stop), .busy(busy)
  );

  always_comb begin
    armed       = enable & busy;
    evt_restart = evt.start | evt.stop | evt.scl_rise | evt.scl_fall;
    scl_restart = evt.scl_lvl | evt.scl_fall;
  end

  i2c_stk_timer #(.LIM_W(LIM_W)) u_evt_tmr (
    .clk(clk), .rst_n(rst_int_n), .armed(armed), .restart(evt_restart),
    .limit(timeout_lim), .flag_clr(clr_evt_to),
    .flag(evt_to_flag), .pulse(evt_to_pulse)
  );

  i2c_stk_timer #(.LIM_W(LIM_W)) u_scl_tmr (
    .clk(clk), .rst_n(rst_int_n), .armed(armed), .restart(scl_restart),
    .limit(timeout_lim), .flag_clr(clr_scl_to),
    .flag(scl_to_flag), .pulse(scl_to_pulse)
  );

  assign bus_busy = busy;
endmodule

// File: rtl/i2c_stk_mon_chk.sv
module i2c_stk_mon_chk #(
  parameter int LIM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [LIM_W-1:0] timeout_lim,
  input logic             clr_evt_to,
  input logic             clr_scl_to,
  input logic             bus_busy,
  input logic             evt_to_flag,
  input logic             evt_to_pulse,
  input logic             scl_to_flag,
  input logic             scl_to_pulse
);
  p_busy_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bus_busy);
  p_evt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_to_flag && !clr_evt_to) |=> evt_to_flag);
  p_scl_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_to_flag && !clr_scl_to) |=> scl_to_flag);
  p_evt_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_to_pulse |=> !evt_to_pulse);
  p_scl_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_to_pulse |=> !scl_to_pulse);
  p_evt_pulse_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_to_pulse |-> evt_to_flag);
  p_zero_lim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_to_flag) |-> ($past(timeout_lim) != '0));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_to_flag) |-> $past(bus_busy));
endmodule

bind i2c_stuck_mon i2c_stk_mon_chk #(.LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .timeout_lim(timeout_lim),
  .clr_evt_to(clr_evt_to), .clr_scl_to(clr_scl_to), .bus_busy(bus_busy),
  .evt_to_flag(evt_to_flag), .evt_to_pulse(evt_to_pulse),
  .scl_to_flag(scl_to_flag), .scl_to_pulse(scl_to_pulse)
);

// File: tb/i2c_stuck_mon_tb_top.sv
`timescale 1ns/1ps
module i2c_stuck_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIM_W      = 16;
  localparam int L          = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             enable;
  logic [LIM_W-1:0] timeout_lim;
  logic             scl_in, sda_in, clr_evt_to, clr_scl_to;
  logic             bus_busy, evt_to_flag, evt_to_pulse, scl_to_flag, scl_to_pulse;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stuck_mon #(.LIM_W(LIM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .timeout_lim(timeout_lim),
    .scl_in(scl_in), .sda_in(sda_in), .clr_evt_to(clr_evt_to), .clr_scl_to(clr_scl_to),
    .bus_busy(bus_busy), .evt_to_flag(evt_to_flag), .evt_to_pulse(evt_to_pulse),
    .scl_to_flag(scl_to_flag), .scl_to_pulse(scl_to_pulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Pass n rising edges and land on a falling edge.
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    scl_in = 1'b0; step(2);
    sda_in = 1'b0; step(2);
    scl_in = 1'b1; step(2);
    sda_in = 1'b1; step(5);
    clr_evt_to = 1'b1; clr_scl_to = 1'b1; step(1);
    clr_evt_to = 1'b0; clr_scl_to = 1'b0; step(1);
  endtask

  task automatic do_start();
    sda_in = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset busy", bus_busy, 1'b0);
    check("R6 reset evt flag", evt_to_flag, 1'b0);
    check("R6 reset scl flag", scl_to_flag, 1'b0);
  endtask

  task automatic t_start_busy();
    do_start(); step(2);
    check("R1 busy not yet", bus_busy, 1'b0);
    step(1);
    check("R1 busy set", bus_busy, 1'b1);
    go_idle();
  endtask

  task automatic t_evt_timeout();
    do_start(); step(L + 3);
    check("R3 evt flag early", evt_to_flag, 1'b0);
    step(1);
    check("R3 evt flag set", evt_to_flag, 1'b1);
    check("R7 evt pulse high", evt_to_pulse, 1'b1);
    check("R5 scl flag with scl high", scl_to_flag, 1'b0);
    step(1);
    check("R7 evt pulse low", evt_to_pulse, 1'b0);
    step(20);
    check("R5 scl high long", scl_to_flag, 1'b0);
    check("R6 evt flag sticky", evt_to_flag, 1'b1);
    // Stop, then clear with no condition pending.
    scl_in = 1'b0; step(2); scl_in = 1'b1; step(2); sda_in = 1'b1; step(3);
    check("R2 busy cleared by stop", bus_busy, 1'b0);
    check("R6 evt flag held after stop", evt_to_flag, 1'b1);
    clr_evt_to = 1'b1; step(1); clr_evt_to = 1'b0;
    check("R6 evt flag cleared", evt_to_flag, 1'b0);
    go_idle();
  endtask

  task automatic t_scl_low();
    do_start(); step(4);
    scl_in = 1'b0; step(L + 3);
    check("R5 scl flag early", scl_to_flag, 1'b0);
    step(1);
    check("R5 scl flag set", scl_to_flag, 1'b1);
    check("R7 scl pulse high", scl_to_pulse, 1'b1);
    check("R3 evt flag with scl stuck", evt_to_flag, 1'b1);
    step(1);
    check("R7 scl pulse low", scl_to_pulse, 1'b0);
    clr_scl_to = 1'b1; step(1); clr_scl_to = 1'b0; step(1);
    check("R6 clear while stuck resets", scl_to_flag, 1'b1);
    go_idle();
  endtask

  task automatic t_toggle();
    do_start(); step(4);
    for (int i = 0; i < 12; i++) begin
      scl_in = 1'b0; step(L - 3);
      scl_in = 1'b1; step(L - 3);
    end
    check("R4 toggling keeps evt low", evt_to_flag, 1'b0);
    check("R4 short low phases keep scl low", scl_to_flag, 1'b0);
    check("R4 still busy", bus_busy, 1'b1);
    go_idle();
  endtask

  task automatic t_idle();
    do_start(); step(L - 2);
    sda_in = 1'b1; step(3);
    check("R2 stop clears busy", bus_busy, 1'b0);
    step(40);
    check("R10 idle no evt", evt_to_flag, 1'b0);
    scl_in = 1'b0; step(40);
    check("R10 idle scl low no flag", scl_to_flag, 1'b0);
    scl_in = 1'b1; step(3);
    go_idle();
  endtask

  task automatic t_zero_lim();
    timeout_lim = '0;
    do_start(); step(4);
    scl_in = 1'b0; step(60);
    check("R8 zero lim evt", evt_to_flag, 1'b0);
    check("R8 zero lim scl", scl_to_flag, 1'b0);
    scl_in = 1'b1; step(2);
    go_idle();
    timeout_lim = LIM_W'(L);
  endtask

  task automatic t_disable();
    enable = 1'b0;
    do_start(); step(4);
    check("R9 start ignored", bus_busy, 1'b0);
    scl_in = 1'b0; step(40);
    check("R9 no evt flag", evt_to_flag, 1'b0);
    check("R9 no scl flag", scl_to_flag, 1'b0);
    scl_in = 1'b1; step(2);
    go_idle();
    enable = 1'b1; step(2);
  endtask

  task automatic t_same_cycle();
    do_start(); step(L + 3);
    check("R11 flag still low", evt_to_flag, 1'b0);
    clr_evt_to = 1'b1; step(1);
    check("R11 set wins flag", evt_to_flag, 1'b1);
    check("R11 set wins pulse", evt_to_pulse, 1'b1);
    step(1);
    check("R11 held by condition", evt_to_flag, 1'b1);
    clr_evt_to = 1'b0;
    go_idle();
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; timeout_lim = LIM_W'(L);
    scl_in = 1'b1; sda_in = 1'b1; clr_evt_to = 1'b0; clr_scl_to = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_start_busy();
    t_evt_timeout();
    t_scl_low();
    t_toggle();
    t_idle();
    t_zero_lim();
    t_disable();
    t_same_cycle();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule